// File: doc/BRIEF.md
# Trap Entry Controller

This block keeps the trap-related control and status state of a simple 64-bit processor core and works out where execution goes when something interrupts the normal flow. The pipeline reports a synchronous fault together with its cause code, the current PC, the instruction word and a flag that marks a translation-refill miss. It can also raise a debug breakpoint. Level-sensitive external interrupt lines feed a pending field. When a trap is accepted, the block saves the interrupted state into one of three register sets (normal, refill or debug). It then issues a single-cycle redirect strobe carrying the target PC.

Targets for normal traps are vectored: base plus code times a spacing, where the spacing is either zero or a programmable power of two. Refill traps go to their own base. Debug entries go to a fixed offset above the normal base. A small configuration write port loads both bases, the spacing field, the local interrupt mask and the current-mode register.

Top module: `trap_entry_ctrl`

## Requirements
- R1: `pend_bits[i]` shows the level that `irq_lines[i]` had at the previous clock edge. `hard_irq` is high whenever any pending bit is set, whatever the mask, enable or debug state.
- R2: An interrupt is taken only when all three conditions hold: `cur_ie`=1, `dbg_active`=0, and `pend_bits & mask` is nonzero. The highest set masked index wins. The target is base + (64 + index) × spacing, and `trap_code` is written with 0.
- R3: The spacing comes from the 3-bit field `cfg_wdata[2:0]`, written with `cfg_sel`=2. A field value of 0 gives a spacing of 0, so every vectored trap lands on the base. Any other value f gives a spacing of 4 << f bytes.
- R4: A non-refill exception does four things: it writes its cause into `trap_code`, copies `cur_plv`/`cur_ie` into `prv_plv`/`prv_ie`, stores `pipe_pc` in `ret_pc`, and redirects to base + cause × spacing.
- R5: Every accepted trap that is not a debug entry leaves `cur_plv`=0 and `cur_ie`=0.
- R6: `bad_addr` is loaded with `pipe_pc` for the causes 0x0B to 0x10 (system call, break, undefined, privileged, floating point, bound check). Every other cause leaves it unchanged.
- R7: `bad_insn` captures `exc_insn` for every exception cause except 0 (interrupt) and 3 (fetch page invalid). Interrupts never change it.
- R8: An exception that has `exc_refill`=1 does the following: it saves plv and ie into `rfl_prv_plv`/`rfl_prv_ie`, sets `cur_da`=1 and `cur_pg`=0, stores `pipe_pc >> 2` in `rfl_ret`, and redirects to the refill base (written with `cfg_sel`=1). It leaves `trap_code`, `prv_*` and `ret_pc` alone.
- R9: A debug breakpoint sets `dbg_bkpt_flag`, writes 0x0C into `dbg_code`, saves `pipe_pc` in `dbg_ret`, sets `dbg_active` and redirects to base + 0x480. It leaves `cur_plv` and `cur_ie` unchanged.
- R10: An interrupt that would be eligible while `dbg_active`=1 is handled through the debug path instead. It sets `dbg_irq_flag` and saves `dbg_ret`. This happens only while `dbg_irq_flag` is still clear.
- R11: When requests coincide, a debug breakpoint wins over a synchronous exception, and a synchronous exception wins over an interrupt.
- R12: `redirect_vld` is high for exactly the one cycle after each clock edge at which a trap is accepted. After reset, all of these are zero: plv, ie, pg, mask, spacing, bases, saved registers and debug flags. `cur_da` is 1.
- R13: The configuration port writes the normal base when `cfg_sel`=0 and the refill base when `cfg_sel`=1. With `cfg_sel`=2 it writes the spacing in bits [2:0] and the mask in bits [28:16]. With `cfg_sel`=3 it writes the mode register: plv in bits [1:0], ie in bit 2, da in bit 3 and pg in bit 4. A mode write in a cycle that accepts a trap is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_cause | input | 6 | Exception cause code |
| exc_refill | input | 1 | Exception is a translation-refill miss |
| dbg_bkpt_req | input | 1 | Debug breakpoint request |
| pipe_pc | input | 64 | PC of the faulting or interrupted instruction |
| exc_insn | input | 32 | Faulting instruction word |
| irq_lines | input | 13 | Level-sensitive interrupt lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_wdata | input | 64 | Configuration write data |
| redirect_vld | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | 64 | Redirect target |
| hard_irq | output | 1 | Some line is pending, before masking |
| pend_bits | output | 13 | Pending interrupt field |
| cur_plv | output | 2 | Current privilege level |
| cur_ie | output | 1 | Global interrupt enable |
| cur_da | output | 1 | Direct-address mode |
| cur_pg | output | 1 | Paged mode |
| prv_plv | output | 2 | Saved privilege level, normal path |
| prv_ie | output | 1 | Saved interrupt enable, normal path |
| trap_code | output | 6 | Last normal-path cause code |
| ret_pc | output | 64 | Normal-path return PC |
| bad_addr | output | 64 | Bad address register |
| bad_insn | output | 32 | Bad instruction register |
| rfl_prv_plv | output | 2 | Saved privilege level, refill path |
| rfl_prv_ie | output | 1 | Saved interrupt enable, refill path |
| rfl_ret | output | 64 | Refill return word address (PC >> 2) |
| dbg_active | output | 1 | Debug state |
| dbg_bkpt_flag | output | 1 | Debug entered by breakpoint |
| dbg_irq_flag | output | 1 | Debug entered by interrupt |
| dbg_code | output | 6 | Debug cause code |
| dbg_ret | output | 64 | Debug return PC |

## Verification
On every cycle, the assertions check the following: the strobe follows acceptance of a trap, non-debug entries clear the privilege level and enable, and interrupts are gated by the enable and debug state. They also check that refill entries switch to direct-address mode and land on the refill base, that debug entries land at base + 0x480, and that a zero spacing field sends vectored traps to the base. Only the bench's scenarios, compared with a reference model, can show the rest: the exact vectored arithmetic for each spacing, the winner among several masked pending lines, which causes touch the bad-address and bad-instruction registers, and arbitration between coincident requests. The same holds for the one-shot debug-interrupt entry and for a mode write dropped behind a trap.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CODE_W = 6;
  localparam logic [CODE_W-1:0] CAUSE_IRQ       = 6'h00;
  localparam logic [CODE_W-1:0] CAUSE_FETCH_INV = 6'h03;
  localparam logic [CODE_W-1:0] CAUSE_BADV_LO   = 6'h0B;
  localparam logic [CODE_W-1:0] CAUSE_BADV_HI   = 6'h10;
  localparam logic [CODE_W-1:0] DBG_BKPT_CODE   = 6'h0C;

  typedef enum logic [1:0] {
    PATH_NONE   = 2'd0,
    PATH_DEBUG  = 2'd1,
    PATH_REFILL = 2'd2,
    PATH_VECTOR = 2'd3
  } trap_path_e;

  function automatic logic cause_sets_badv(input logic [CODE_W-1:0] c);
    return (c >= CAUSE_BADV_LO) && (c <= CAUSE_BADV_HI);
  endfunction

  function automatic logic cause_sets_badi(input logic [CODE_W-1:0] c);
    return (c != CAUSE_IRQ) && (c != CAUSE_FETCH_INV);
  endfunction
endpackage

// File: rtl/trap_irq_pick.sv
module trap_irq_pick #(
  parameter int NUM_IRQ = 13,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] mask,
  output logic               any_hit,
  output logic [IDX_W-1:0]   win_idx
);
  logic [NUM_IRQ-1:0] hit;
  assign hit     = pend & mask;
  assign any_hit = |hit;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (hit[i]) win_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/trap_tgt_calc.sv
module trap_tgt_calc
  import trap_pkg::*;
#(
  parameter int          XLEN    = 64,
  parameter int          VS_W    = 3,
  parameter logic [63:0] DBG_OFS = 64'h480
) (
  input  trap_path_e        path,
  input  logic [XLEN-1:0]   code,
  input  logic [VS_W-1:0]   vs,
  input  logic [XLEN-1:0]   vec_base,
  input  logic [XLEN-1:0]   rfl_base,
  output logic [XLEN-1:0]   target
);
  function automatic logic [XLEN-1:0] vec_offset(input logic [XLEN-1:0] c,
                                                 input logic [VS_W-1:0] f);
    if (f == '0) return '0;
    return c << (32'(f) + 32'd2);
  endfunction

  always_comb begin
    unique case (path)
      PATH_DEBUG:  target = vec_base + XLEN'(DBG_OFS);
      PATH_REFILL: target = rfl_base;
      PATH_VECTOR: target = vec_base + vec_offset(code, vs);
      default:     target = vec_base;
    endcase
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int          XLEN    = 64,
  parameter int          INSN_W  = 32,
  parameter int          NUM_IRQ = 13,
  parameter int          INT_OFS = 64,
  parameter int          VS_W    = 3,
  parameter int          MASK_LSB = 16,
  parameter logic [63:0] DBG_OFS = 64'h480
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exc_req,
  input  logic [CODE_W-1:0]   exc_cause,
  input  logic                exc_refill,
  input  logic                dbg_bkpt_req,
  input  logic [XLEN-1:0]     pipe_pc,
  input  logic [INSN_W-1:0]   exc_insn,
  input  logic [NUM_IRQ-1:0]  irq_lines,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_sel,
  input  logic [XLEN-1:0]     cfg_wdata,
  output logic                redirect_vld,
  output logic [XLEN-1:0]     redirect_pc,
  output logic                hard_irq,
  output logic [NUM_IRQ-1:0]  pend_bits,
  output logic [1:0]          cur_plv,
  output logic                cur_ie,
  output logic                cur_da,
  output logic                cur_pg,
  output logic [1:0]          prv_plv,
  output logic                prv_ie,
  output logic [CODE_W-1:0]   trap_code,
  output logic [XLEN-1:0]     ret_pc,
  output logic [XLEN-1:0]     bad_addr,
  output logic [INSN_W-1:0]   bad_insn,
  output logic [1:0]          rfl_prv_plv,
  output logic                rfl_prv_ie,
  output logic [XLEN-1:0]     rfl_ret,
  output logic                dbg_active,
  output logic                dbg_bkpt_flag,
  output logic                dbg_irq_flag,
  output logic [CODE_W-1:0]   dbg_code,
  output logic [XLEN-1:0]     dbg_ret
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] mask_q;
  logic [VS_W-1:0]    vs_q;
  logic [XLEN-1:0]    ebase_q, rbase_q;

  // named trap events
  logic               irq_any;
  logic [IDX_W-1:0]   irq_idx;
  logic               irq_elig;
  logic               take_bkpt, take_exc, take_refill;
  logic               take_irq_nd, take_irq_dbg;
  logic               take_dbg, take_nd, take_vec, take_any;
  trap_path_e         path;
  logic [XLEN-1:0]    tgt_code, tgt_pc;

  trap_irq_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .pend    (pend_bits),
    .mask    (mask_q),
    .any_hit (irq_any),
    .win_idx (irq_idx)
  );

  assign irq_elig     = cur_ie && irq_any && !dbg_bkpt_req && !exc_req;
  assign take_bkpt    = dbg_bkpt_req;
  assign take_exc     = exc_req && !dbg_bkpt_req;
  assign take_refill  = take_exc && exc_refill;
  assign take_irq_nd  = irq_elig && !dbg_active;
  assign take_irq_dbg = irq_elig && dbg_active && !dbg_irq_flag;
  assign take_dbg     = take_bkpt || take_irq_dbg;
  assign take_nd      = take_exc || take_irq_nd;
  assign take_vec     = take_nd && !take_refill;
  assign take_any     = take_dbg || take_nd;

  always_comb begin
    if (take_dbg)         path = PATH_DEBUG;
    else if (take_refill) path = PATH_REFILL;
    else if (take_vec)    path = PATH_VECTOR;
    else                  path = PATH_NONE;
  end

  assign tgt_code = take_exc ? XLEN'(exc_cause) : (XLEN'(INT_OFS) + XLEN'(irq_idx));

  trap_tgt_calc #(.XLEN(XLEN), .VS_W(VS_W), .DBG_OFS(DBG_OFS)) u_tgt (
    .path     (path),
    .code     (tgt_code),
    .vs       (vs_q),
    .vec_base (ebase_q),
    .rfl_base (rbase_q),
    .target   (tgt_pc)
  );

  assign hard_irq = |pend_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_bits     <= '0;
      mask_q        <= '0;
      vs_q          <= '0;
      ebase_q       <= '0;
      rbase_q       <= '0;
      redirect_vld  <= 1'b0;
      redirect_pc   <= '0;
      cur_plv       <= '0;
      cur_ie        <= 1'b0;
      cur_da        <= 1'b1;
      cur_pg        <= 1'b0;
      prv_plv       <= '0;
      prv_ie        <= 1'b0;
      trap_code     <= '0;
      ret_pc        <= '0;
      bad_addr      <= '0;
      bad_insn      <= '0;
      rfl_prv_plv   <= '0;
      rfl_prv_ie    <= 1'b0;
      rfl_ret       <= '0;
      dbg_active    <= 1'b0;
      dbg_bkpt_flag <= 1'b0;
      dbg_irq_flag  <= 1'b0;
      dbg_code      <= '0;
      dbg_ret       <= '0;
    end else begin
      pend_bits    <= irq_lines;
      redirect_vld <= take_any;
      if (take_any) redirect_pc <= tgt_pc;

      if (cfg_we) begin
        unique case (cfg_sel)
          2'd0: ebase_q <= cfg_wdata;
          2'd1: rbase_q <= cfg_wdata;
          2'd2: begin
            vs_q   <= cfg_wdata[VS_W-1:0];
            mask_q <= cfg_wdata[MASK_LSB +: NUM_IRQ];
          end
          default: if (!take_any) begin
            cur_plv <= cfg_wdata[1:0];
            cur_ie  <= cfg_wdata[2];
            cur_da  <= cfg_wdata[3];
            cur_pg  <= cfg_wdata[4];
          end
        endcase
      end

      if (take_exc) begin
        if (cause_sets_badv(exc_cause)) bad_addr <= pipe_pc;
        if (cause_sets_badi(exc_cause)) bad_insn <= exc_insn;
      end

      if (take_refill) begin
        rfl_prv_plv <= cur_plv;
        rfl_prv_ie  <= cur_ie;
        cur_da      <= 1'b1;
        cur_pg      <= 1'b0;
        rfl_ret     <= pipe_pc >> 2;
      end

      if (take_vec) begin
        trap_code <= take_exc ? exc_cause : CAUSE_IRQ;
        prv_plv   <= cur_plv;
        prv_ie    <= cur_ie;
        ret_pc    <= pipe_pc;
      end

      if (take_nd) begin
        cur_plv <= '0;
        cur_ie  <= 1'b0;
      end

      if (take_dbg) begin
        dbg_active <= 1'b1;
        dbg_ret    <= pipe_pc;
        if (take_bkpt) begin
          dbg_bkpt_flag <= 1'b1;
          dbg_code      <= DBG_BKPT_CODE;
        end else begin
          dbg_irq_flag  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int          XLEN    = 64,
  parameter int          VS_W    = 3,
  parameter logic [63:0] DBG_OFS = 64'h480
) (
  input logic            clk,
  input logic            rst_n,
  input logic            take_any,
  input logic            take_nd,
  input logic            take_vec,
  input logic            take_dbg,
  input logic            take_irq_nd,
  input logic            take_refill,
  input logic            redirect_vld,
  input logic [XLEN-1:0] redirect_pc,
  input logic [1:0]      cur_plv,
  input logic            cur_ie,
  input logic            cur_da,
  input logic            cur_pg,
  input logic            dbg_active,
  input logic [VS_W-1:0] vs_q,
  input logic [XLEN-1:0] ebase_q,
  input logic [XLEN-1:0] rbase_q
);
  AST_STROBE_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    take_any |=> redirect_vld); // R12
  AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !take_any |=> !redirect_vld); // R12
  AST_MODE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    take_nd |=> (cur_plv == 2'd0 && !cur_ie)); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_nd |-> (cur_ie && !dbg_active)); // R2
  AST_REFILL_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    take_refill |=> (cur_da && !cur_pg && redirect_pc == $past(rbase_q))); // R8
  AST_DEBUG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    take_dbg |=> (dbg_active && redirect_pc == $past(ebase_q) + XLEN'(DBG_OFS))); // R9
  AST_ZERO_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (take_vec && vs_q == '0) |=> redirect_pc == $past(ebase_q)); // R3
endmodule

bind trap_entry_ctrl trap_entry_chk #(.XLEN(XLEN), .VS_W(VS_W), .DBG_OFS(DBG_OFS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .take_any     (take_any),
  .take_nd      (take_nd),
  .take_vec     (take_vec),
  .take_dbg     (take_dbg),
  .take_irq_nd  (take_irq_nd),
  .take_refill  (take_refill),
  .redirect_vld (redirect_vld),
  .redirect_pc  (redirect_pc),
  .cur_plv      (cur_plv),
  .cur_ie       (cur_ie),
  .cur_da       (cur_da),
  .cur_pg       (cur_pg),
  .dbg_active   (dbg_active),
  .vs_q         (vs_q),
  .ebase_q      (ebase_q),
  .rbase_q      (rbase_q)
);

// File: tb/trap_entry_ctrl_tb.sv
module trap_entry_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 0, exc_refill = 0, dbg_bkpt_req = 0, cfg_we = 0;
  logic [5:0]  exc_cause = 0;
  logic [63:0] pipe_pc = 0, cfg_wdata = 0;
  logic [31:0] exc_insn = 0;
  logic [NIRQ-1:0] irq_lines = 0;
  logic [1:0]  cfg_sel = 0;

  logic        redirect_vld, hard_irq, cur_ie, cur_da, cur_pg, prv_ie, rfl_prv_ie;
  logic        dbg_active, dbg_bkpt_flag, dbg_irq_flag;
  logic [63:0] redirect_pc, ret_pc, bad_addr, rfl_ret, dbg_ret;
  logic [31:0] bad_insn;
  logic [NIRQ-1:0] pend_bits;
  logic [1:0]  cur_plv, prv_plv, rfl_prv_plv;
  logic [5:0]  trap_code, dbg_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
    .exc_refill(exc_refill), .dbg_bkpt_req(dbg_bkpt_req), .pipe_pc(pipe_pc),
    .exc_insn(exc_insn), .irq_lines(irq_lines), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .redirect_vld(redirect_vld), .redirect_pc(redirect_pc),
    .hard_irq(hard_irq), .pend_bits(pend_bits), .cur_plv(cur_plv), .cur_ie(cur_ie),
    .cur_da(cur_da), .cur_pg(cur_pg), .prv_plv(prv_plv), .prv_ie(prv_ie),
    .trap_code(trap_code), .ret_pc(ret_pc), .bad_addr(bad_addr), .bad_insn(bad_insn),
    .rfl_prv_plv(rfl_prv_plv), .rfl_prv_ie(rfl_prv_ie), .rfl_ret(rfl_ret),
    .dbg_active(dbg_active), .dbg_bkpt_flag(dbg_bkpt_flag), .dbg_irq_flag(dbg_irq_flag),
    .dbg_code(dbg_code), .dbg_ret(dbg_ret)
  );

  // behavioural reference model
  logic        m_vld, m_ie, m_da, m_pg, m_pie, m_rie, m_dbg, m_dcl, m_dei;
  logic [63:0] m_pc, m_era, m_badv, m_rera, m_dera, m_ebase, m_rbase;
  logic [31:0] m_badi;
  logic [NIRQ-1:0] m_pend, m_mask;
  logic [1:0]  m_plv, m_pplv, m_rplv;
  logic [5:0]  m_code, m_dcode;
  logic [2:0]  m_vs;
  logic        started = 1'b0;

  always @(posedge clk) begin
    longint unsigned sp;
    int hi;
    logic bk, ex, irq_ok, in_n, in_d, trap;
    started = 1'b1;
    if (!rst_n) begin
      m_vld = 0; m_pc = 0; m_plv = 0; m_ie = 0; m_da = 1; m_pg = 0;
      m_pplv = 0; m_pie = 0; m_code = 0; m_era = 0; m_badv = 0; m_badi = 0;
      m_rplv = 0; m_rie = 0; m_rera = 0; m_dbg = 0; m_dcl = 0; m_dei = 0;
      m_dcode = 0; m_dera = 0; m_pend = 0; m_mask = 0; m_vs = 0;
      m_ebase = 0; m_rbase = 0;
    end else begin
      hi = -1;
      for (int i = 0; i < NIRQ; i++) if (m_pend[i] && m_mask[i]) hi = i;
      sp = (m_vs == 0) ? 0 : (longint'(4) << m_vs);
      bk = dbg_bkpt_req;                 // R11 order: breakpoint, exception, interrupt
      ex = exc_req && !bk;
      irq_ok = m_ie && (hi >= 0) && !bk && !exc_req;
      in_n = irq_ok && !m_dbg;
      in_d = irq_ok && m_dbg && !m_dei;
      trap = bk || ex || in_n || in_d;
      m_vld = trap;
      if (bk || in_d) begin
        m_pc = m_ebase + 64'h480;
        m_dbg = 1; m_dera = pipe_pc;
        if (bk) begin m_dcl = 1; m_dcode = 6'h0C; end else m_dei = 1;
      end else if (ex) begin
        if (exc_cause >= 6'h0B && exc_cause <= 6'h10) m_badv = pipe_pc;
        if (exc_cause != 6'h00 && exc_cause != 6'h03) m_badi = exc_insn;
        if (exc_refill) begin
          m_rplv = m_plv; m_rie = m_ie; m_da = 1; m_pg = 0;
          m_rera = {2'b00, pipe_pc[63:2]}; m_pc = m_rbase;
        end else begin
          m_code = exc_cause; m_pplv = m_plv; m_pie = m_ie; m_era = pipe_pc;
          m_pc = m_ebase + longint'(exc_cause) * sp;
        end
        m_plv = 0; m_ie = 0;
      end else if (in_n) begin
        m_code = 0; m_pplv = m_plv; m_pie = m_ie; m_era = pipe_pc;
        m_pc = m_ebase + longint'(64 + hi) * sp;
        m_plv = 0; m_ie = 0;
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_ebase = cfg_wdata;
          2'd1: m_rbase = cfg_wdata;
          2'd2: begin m_vs = cfg_wdata[2:0]; m_mask = cfg_wdata[28:16]; end
          default: if (!trap) begin
            m_plv = cfg_wdata[1:0]; m_ie = cfg_wdata[2];
            m_da = cfg_wdata[3]; m_pg = cfg_wdata[4];
          end
        endcase
      end
      m_pend = irq_lines;
    end
  end

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string tag, input string nm, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %h expected %h", tag, nm, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R12", "redirect_vld", 64'(redirect_vld), 64'(m_vld));
      chk("R2/R3/R4/R8/R9/R11", "redirect_pc", redirect_pc, m_pc);
      chk("R1", "pend_bits", 64'(pend_bits), 64'(m_pend));
      chk("R1", "hard_irq", 64'(hard_irq), 64'(|m_pend));
      chk("R5/R13", "cur_mode", {59'd0, cur_pg, cur_da, cur_ie, cur_plv},
          {59'd0, m_pg, m_da, m_ie, m_plv});
      chk("R4", "prv", {61'd0, prv_ie, prv_plv}, {61'd0, m_pie, m_pplv});
      chk("R4", "trap_code", 64'(trap_code), 64'(m_code));
      chk("R4", "ret_pc", ret_pc, m_era);
      chk("R6", "bad_addr", bad_addr, m_badv);
      chk("R7", "bad_insn", 64'(bad_insn), 64'(m_badi));
      chk("R8", "rfl_prv", {61'd0, rfl_prv_ie, rfl_prv_plv}, {61'd0, m_rie, m_rplv});
      chk("R8", "rfl_ret", rfl_ret, m_rera);
      chk("R9", "dbg_state", {56'd0, dbg_code, dbg_active, dbg_bkpt_flag},
          {56'd0, m_dcode, m_dbg, m_dcl});
      chk("R9", "dbg_ret", dbg_ret, m_dera);
      chk("R10", "dbg_irq_flag", 64'(dbg_irq_flag), 64'(m_dei));
    end
  end

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 50000) begin
      n_cmp++; n_bad++;
      $display("FAIL R12 watchdog: actual %0d cycles expected below 50000", wd_cnt);
      summary_and_end();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] s, input logic [63:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic fault(input logic [5:0] c, input logic rf, input logic [63:0] pc, input logic [31:0] ins);
    @(negedge clk); exc_req = 1; exc_cause = c; exc_refill = rf; pipe_pc = pc; exc_insn = ins;
    @(negedge clk); exc_req = 0; exc_refill = 0;
    idle(2);
  endtask

  task automatic mode(input logic [4:0] m);   // R13 {pg,da,ie,plv}
    cfg(2'd3, 64'(m));
  endtask

  initial begin
    idle(3);                                     // R12 reset values compared here
    @(negedge clk); rst_n = 1;
    idle(1);
    cfg(2'd0, 64'h1000);                         // R13 bases
    cfg(2'd1, 64'h8000);
    cfg(2'd2, {35'd0, 13'h1FFF, 13'd0, 3'd0});   // R3 spacing 0, full mask
    mode(5'b01011);
    fault(6'h0B, 0, 64'h2000, 32'hAAAA0001);     // R6 R7 R4 zero spacing
    cfg(2'd2, {35'd0, 13'h1FFF, 13'd0, 3'd1});   // R3 spacing 8
    fault(6'h01, 0, 64'h2004, 32'hAAAA0002);     // R6 unchanged, R7 captured
    fault(6'h03, 0, 64'h2008, 32'hAAAA0003);     // R7 unchanged
    fault(6'h10, 0, 64'h200C, 32'hAAAA0004);     // R6 upper bound
    cfg(2'd2, {35'd0, 13'h1FFF, 13'd0, 3'd3});   // spacing 32
    mode(5'b10111);
    fault(6'h01, 1, 64'h3000, 32'hBBBB0001);     // R8 refill
    // R1 R2 interrupts: lines 2 and 7, highest wins
    mode(5'b01110);
    @(negedge clk); pipe_pc = 64'h4000; irq_lines = 13'h084;
    idle(3);
    irq_lines = 0; idle(2);
    // R2 masked: only bit 2 enabled
    cfg(2'd2, {35'd0, 13'h0004, 13'd0, 3'd2});
    @(negedge clk); irq_lines = 13'h080;
    idle(3);                                     // R1 hard_irq without trap
    mode(5'b01101);
    idle(2);
    @(negedge clk); irq_lines = 13'h084; idle(3);
    irq_lines = 0; idle(2);
    // R2 enable clear blocks
    @(negedge clk); irq_lines = 13'h004; idle(3);
    // R11 exception and interrupt together, R13 mode write dropped
    @(negedge clk); cfg_we = 1; cfg_sel = 2'd3; cfg_wdata = 64'h0F;
    exc_req = 1; exc_cause = 6'h0D; pipe_pc = 64'h5000;
    @(negedge clk); exc_req = 0; cfg_we = 0;
    mode(5'b01111);
    idle(1);
    @(negedge clk); exc_req = 1; exc_cause = 6'h0E; pipe_pc = 64'h5100;
    @(negedge clk); exc_req = 0;
    irq_lines = 0; idle(2);
    mode(5'b01111);
    // R9 breakpoint with exception same cycle (R11)
    @(negedge clk); dbg_bkpt_req = 1; exc_req = 1; exc_cause = 6'h0B; pipe_pc = 64'h6000;
    @(negedge clk); dbg_bkpt_req = 0; exc_req = 0;
    idle(2);
    // R10 interrupt during debug: one entry only
    @(negedge clk); pipe_pc = 64'h6100; irq_lines = 13'h004;
    idle(6);
    irq_lines = 0;
    // random phase
    @(negedge clk); rst_n = 0; idle(2); rst_n = 1;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (k == 300) begin rst_n = 0; end
      if (k == 302) begin rst_n = 1; end
      exc_req = ($urandom % 6) == 0;
      exc_cause = 6'($urandom % 18);
      exc_refill = ($urandom % 4) == 0;
      dbg_bkpt_req = ($urandom % 80) == 0;
      irq_lines = NIRQ'($urandom);
      pipe_pc = {$urandom, $urandom};
      exc_insn = $urandom;
      cfg_we = ($urandom % 3) == 0;
      cfg_sel = 2'($urandom % 4);
      cfg_wdata = {$urandom, $urandom};
    end
    @(negedge clk); exc_req = 0; dbg_bkpt_req = 0; cfg_we = 0; irq_lines = 0;
    idle(3);
    summary_and_end();
  end
endmodule